// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block manages the low-power rest state of a synchronous memory macro. An asynchronous, active-high rest request is brought into the clock domain through a short flop chain. A sequencer then walks through a fixed number of entry cycles before it declares the memory asleep, and a fixed number of wake cycles after the request drops. From the first entry cycle until the last wake cycle it raises an inhibit line. The access controller uses this line to refuse new cycles, to block every write, and to hold the data pins at high impedance. Array contents are not touched, so they remain intact across the rest period.

The sequencer also polices the neighbouring logic. It raises a sticky violation flag in two cases: the access controller is not deselected while entry is under way, or an access request appears in the recovery window that follows the release of the rest request. The flag holds until reset. Power switching and the array itself belong to other blocks.

Top module: `slp_ctrl`

## Requirements
- R1: A synchronous active-high reset clears `sleep_active`, `access_inhibit` and `violation` to 0. All three read 0 on the first cycle after reset is released.
- R2: `sleep_req` passes through SYNC_STAGES flops (default 2). `access_inhibit` rises on the SYNC_STAGES+1-th rising edge after the first edge that samples the request high. The outputs do not change on the edges before that one.
- R3: `sleep_active` rises ENTRY_CYC rising edges (default 2) after `access_inhibit` rises, as long as the request stays high.
- R4: Once the request is low, `sleep_active` and `access_inhibit` fall together. This happens on the SYNC_STAGES+1+EXIT_CYC-th rising edge (default 5th) after the first edge that samples the request low.
- R5: Whenever `sleep_active` is 1, `access_inhibit` is 1.
- R6: The recovery window runs from the cycle in which the synchronized request is low while the block is asleep until wake-up completes. An `access_req` of 1 sampled in that window sets `violation` on that edge.
- R7: An entry is under way when the synchronized request is high while the block is awake, and through every entry cycle. A `deselected` of 0 sampled while an entry is under way sets `violation` on that edge.
- R8: Once `violation` is 1 it stays 1 until reset, whatever the inputs do.
- R9: An `access_req` of 1 has no effect on `violation` when it is sampled while the block is awake and idle, or while the block is asleep with the synchronized request still high.
- R10: If the synchronized request drops before the entry cycles finish, the block returns to awake on the next edge and clears `access_inhibit` there. `sleep_active` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Asynchronous rest request, active high |
| access_req | input | 1 | Decoded request for a new access from the access controller |
| deselected | input | 1 | Access controller reports the memory deselected |
| sleep_active | output | 1 | Memory is in, or waking from, the rest state |
| access_inhibit | output | 1 | Block accesses and writes, hold data pins at high impedance |
| violation | output | 1 | Sticky protocol violation flag |

## Verification
The recovery window is the hardest case to reach. It opens only after a full entry and a full synchronized release, and an access request then has to land in exactly one of the few wake cycles. The stimulus first takes the block fully asleep. It then releases the request and counts the edges through the synchronizer. The access request is raised on the first wake cycle, and the bench confirms that the flag is set and stays set while the wake sequence finishes. An aborted entry, where the request is released during the entry cycles, is reached in the same way: a one-cycle request pulse is timed against the synchronizer delay.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        SLP_AWAKE  = 2'd0,
        SLP_ENTER  = 2'd1,
        SLP_ASLEEP = 2'd2,
        SLP_WAKE   = 2'd3
    } slp_state_e;

    typedef struct packed {
        logic asleep;
        logic inhibit;
    } slp_flags_t;

    function automatic slp_flags_t slp_decode(slp_state_e s);
        slp_flags_t f;
        f.asleep  = (s == SLP_ASLEEP) || (s == SLP_WAKE);
        f.inhibit = (s != SLP_AWAKE);
        return f;
    endfunction

    function automatic int unsigned slp_cnt_width(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES < 2) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b0;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
#(
    parameter int unsigned ENTRY_CYC = 2,
    parameter int unsigned EXIT_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_s,
    output slp_state_e state
);
    localparam int unsigned CW = slp_cnt_width(ENTRY_CYC, EXIT_CYC);
    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);

    slp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLP_AWAKE:  if (req_s) state_d = SLP_ENTER;
            SLP_ENTER: begin
                if (!req_s)                   state_d = SLP_AWAKE;
                else if (cnt_q == ENTRY_LAST) state_d = SLP_ASLEEP;
            end
            SLP_ASLEEP: if (!req_s) state_d = SLP_WAKE;
            SLP_WAKE:   if (cnt_q == EXIT_LAST) state_d = SLP_AWAKE;
            default:    state_d = SLP_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLP_AWAKE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q == SLP_ENTER || state_q == SLP_WAKE)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/slp_guard.sv
module slp_guard
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slp_state_e state,
    input  logic       req_s,
    input  logic       access_req,
    input  logic       deselected,
    output logic       violation
);
    logic in_recovery, in_entry, bad, viol_q;

    assign in_recovery = (state == SLP_WAKE) || (state == SLP_ASLEEP && !req_s);
    assign in_entry    = (state == SLP_ENTER) || (state == SLP_AWAKE && req_s);
    assign bad         = (in_recovery && access_req) || (in_entry && !deselected);

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= viol_q | bad;
    end

    assign violation = viol_q;
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ENTRY_CYC   = 2,
    parameter int unsigned EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic access_req,
    input  logic deselected,
    output logic sleep_active,
    output logic access_inhibit,
    output logic violation
);
    logic       req_sync;
    slp_state_e state;
    slp_flags_t flags;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(sleep_req), .q(req_sync)
    );

    slp_seq #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_seq (
        .clk(clk), .rst(rst), .req_s(req_sync), .state(state)
    );

    slp_guard u_guard (
        .clk(clk), .rst(rst), .state(state), .req_s(req_sync),
        .access_req(access_req), .deselected(deselected), .violation(violation)
    );

    assign flags          = slp_decode(state);
    assign sleep_active   = flags.asleep;
    assign access_inhibit = flags.inhibit;
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_sync,
    input logic access_req,
    input logic sleep_active,
    input logic access_inhibit,
    input logic violation
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!violation && !access_inhibit && !sleep_active));

    // R5
    a_r5_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
        sleep_active |-> access_inhibit);

    // R3
    a_r3_inhibit_first: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_active) |-> $past(access_inhibit));

    // R4
    a_r4_exit_together: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_active) |-> !access_inhibit);

    // R6
    a_r6_recovery_flag: assert property (@(posedge clk) disable iff (rst)
        (sleep_active && !req_sync && access_req) |=> violation);

    // R8
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .req_sync(req_sync), .access_req(access_req),
    .sleep_active(sleep_active), .access_inhibit(access_inhibit), .violation(violation)
);

// File: tb/slp_ctrl_test.sv
module slp_ctrl_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 13;
    // {sleep_req, access_req, deselected, exp_sleep, exp_inhibit, exp_violation}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b001_000, 6'b101_000, 6'b101_000, 6'b101_010, 6'b101_010,
        6'b101_110, 6'b111_110, 6'b001_110, 6'b001_110, 6'b001_110,
        6'b001_110, 6'b001_000, 6'b011_000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0, access_req = 1'b0, deselected = 1'b1;
    logic sleep_active, access_inhibit, violation;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slp_ctrl uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .access_req(access_req),
        .deselected(deselected), .sleep_active(sleep_active),
        .access_inhibit(access_inhibit), .violation(violation)
    );

    task automatic step(input logic r, input logic a, input logic d);
        @(negedge clk);
        sleep_req = r; access_req = a; deselected = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {sleep_active, access_inhibit, violation};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {sleep,inhibit,viol} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; sleep_req = 1'b0; access_req = 1'b0; deselected = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 reset state", 3'b000);

        // R2 R3 R4 R5 R9: full entry, asleep with access, release, wake
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            chk($sformatf("R2/R3/R4/R9 vector %0d", i), VEC[i][2:0]);
        end

        // R6: access request on first wake cycle
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
        chk("R3 asleep before recovery test", 3'b110);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
        chk("R6 in wake, no flag yet", 3'b110);
        step(1'b0, 1'b1, 1'b1);
        chk("R6 access in recovery flags", 3'b111);
        step(1'b0, 1'b0, 1'b1);
        chk("R8 flag held, wake done", 3'b001);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
        chk("R8 flag still held", 3'b001);

        do_reset();
        chk("R1 reset clears flag", 3'b000);

        // R7: not deselected at entry
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R7 no flag before sync", 3'b000);
        step(1'b1, 1'b0, 1'b0);
        chk("R7 entry while selected flags", 3'b011);

        do_reset();
        chk("R1 reset again", 3'b000);

        // R10: short pulse aborts entry
        step(1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R10 pulse still in sync", 3'b000);
        step(1'b0, 1'b0, 1'b1);
        chk("R10 entry begins", 3'b010);
        step(1'b0, 1'b0, 1'b1);
        chk("R10 aborted to awake", 3'b000);
        step(1'b0, 1'b0, 1'b1);
        chk("R10 never asleep", 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule